// File: doc/BRIEF.md
# Sampling Link with Freshness Tag

This block is a one-way channel between a producing node and a consuming node. Each node has its own trigger. The producer can overwrite a shared word at any time. Every overwrite also advances a sequence tag that is stored next to the word. The consumer can look at the shared word at any time, and it keeps a private copy of the tag it saw at its last read. A fresh flag reports whether the shared tag differs from that private copy, which tells the consumer whether something new has arrived since it last read.

Neither side ever waits on the other. A write always overwrites. A read always returns whatever is stored, even if the consumer has already read it. Both sides sit in one clock domain here and are triggered by single-cycle enables. The read port is combinational from the stored state, so a read in cycle t sees the contents as of the start of cycle t. The private tag is updated at the end of that cycle.

Top module: `sample_link`

## Requirements
- R1: While reset (active low, synchronous) is held and immediately after it, `rd_data` is 0, `rd_seq` is 0 and `rd_fresh` is 0.
- R2: A cycle with `wr_en` high stores `wr_data`. From the next cycle, `rd_data` shows that word and `rd_seq` shows the previous tag plus one.
- R3: In a cycle with `wr_en` low, the stored word and tag do not change.
- R4: `rd_fresh` is 1 exactly when the stored tag differs from the tag captured at the consumer's last read, and 0 when they are equal.
- R5: A cycle with `rd_en` high returns the current word and tag on `rd_data`/`rd_seq` in that cycle, and captures that tag as the consumer's last-read tag at the clock edge. With no write in the same cycle, `rd_fresh` is 0 afterwards.
- R6: When `wr_en` and `rd_en` are high in the same cycle, the read returns the old word, the old tag and the old fresh value, and `rd_fresh` is 1 in the following cycle.
- R7: The tag is `SEQ_W` bits wide (8 by default) and wraps modulo 2^SEQ_W. After exactly 256 writes with no read, the tags alias, `rd_fresh` is 0 and `rd_seq` is back to its earlier value.
- R8: Repeated reads with no write between them are never stalled. They return the same stale word with `rd_fresh` at 0.
- R9: In a cycle with `rd_en` low, the last-read tag is unchanged. With no write either, `rd_fresh` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both node triggers |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Producer trigger: store `wr_data` this cycle |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Consumer trigger: consume the current contents this cycle |
| rd_data | output | DATA_W | Currently stored word |
| rd_seq | output | SEQ_W | Currently stored sequence tag |
| rd_fresh | output | 1 | Stored tag differs from the consumer's last-read tag |

## Verification
The assertions check the following every cycle:
- each write advances the tag by one and lands the written word;
- the contents hold when there is no write;
- a read alone clears freshness;
- a write together with a read sets it;
- freshness holds when neither trigger fires.

Some behaviour only the bench scenarios can show. One is the value that a read sees in the very cycle it is issued, which is compared against a scoreboard model. Another is the aliasing after 256 unread writes. A third is the return to zero at reset.

// File: rtl/sample_link_pkg.sv
// Package: shared defaults and helpers for the sampling link.
// Assumes: sequence tags are plain unsigned counters that wrap.
package sample_link_pkg;
    localparam int unsigned DATA_W_DEFAULT = 32;
    localparam int unsigned SEQ_W_DEFAULT  = 8;

    // Next tag value, modulo 2^SEQ_W (width handled by the caller's cast).
    function automatic logic [31:0] tag_advance(input logic [31:0] cur);
        return cur + 32'd1;
    endfunction
endpackage

// File: rtl/sample_link_writer.sv
// Producer side: owns the shared word and its sequence tag.
// Assumes: a single producer and a single-cycle write trigger.
module sample_link_writer
    import sample_link_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEFAULT,
    parameter int unsigned SEQ_W  = SEQ_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word_q,
    output logic [SEQ_W-1:0]  tag_q
);
    logic [31:0] tag_wide;

    // Widen the tag so the package helper can advance it.
    always_comb tag_wide = 32'(tag_q);

    // Store the word and advance the tag on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            tag_q  <= '0;
        end else if (wr_en) begin
            word_q <= wr_data;
            tag_q  <= SEQ_W'(tag_advance(tag_wide));
        end
    end
endmodule

// File: rtl/sample_link_reader.sv
// Consumer side: keeps the tag of the last consumed word.
// Assumes: a single consumer. A read captures the tag seen in that cycle.
module sample_link_reader #(
    parameter int unsigned SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [SEQ_W-1:0] tag_now,
    output logic [SEQ_W-1:0] last_tag_q
);
    // Capture the tag current at the read.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_tag_q <= '0;
        else if (rd_en) last_tag_q <= tag_now;
    end
endmodule

// File: rtl/sample_link_fresh.sv
// Freshness compare: equality of the stored tag and the last-read tag.
// Assumes: the consumer polls at least once per 2^SEQ_W writes.
module sample_link_fresh #(
    parameter int unsigned SEQ_W = 8
) (
    input  logic [SEQ_W-1:0] tag_now,
    input  logic [SEQ_W-1:0] tag_seen,
    output logic             fresh
);
    logic [SEQ_W-1:0] diff;

    // Bitwise mismatch between the two tags.
    always_comb diff = tag_now ^ tag_seen;

    // Fresh when any bit differs.
    always_comb fresh = |diff;
endmodule

// File: rtl/sample_link.sv
// Top: non-blocking single-writer single-reader sampling channel.
// Assumes: both triggers are in the clk domain. Reads are combinational views.
module sample_link
    import sample_link_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEFAULT,
    parameter int unsigned SEQ_W  = SEQ_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEQ_W-1:0]  rd_seq,
    output logic              rd_fresh
);
    logic [DATA_W-1:0] word_q;
    logic [SEQ_W-1:0]  tag_q;
    logic [SEQ_W-1:0]  last_tag_q;

    sample_link_writer #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .word_q(word_q), .tag_q(tag_q)
    );

    sample_link_reader #(.SEQ_W(SEQ_W)) u_reader (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .tag_now(tag_q), .last_tag_q(last_tag_q)
    );

    sample_link_fresh #(.SEQ_W(SEQ_W)) u_fresh (
        .tag_now(tag_q), .tag_seen(last_tag_q), .fresh(rd_fresh)
    );

    // Present the stored contents to the consumer.
    always_comb begin
        rd_data = word_q;
        rd_seq  = tag_q;
    end
endmodule

// File: rtl/sample_link_chk.sv
// Checker: temporal properties of the sampling link, bound to the top.
// Assumes: it observes only the top-level ports.
module sample_link_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEQ_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [SEQ_W-1:0]  rd_seq,
    input logic              rd_fresh
);
    // R2: a write advances the tag by one.
    a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_seq == SEQ_W'($past(rd_seq) + 1'b1));

    // R2: a write lands the written word.
    a_r2_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    // R3: no write, no change to the contents.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_seq) && $stable(rd_data)));

    // R5: a read alone clears freshness.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !rd_fresh);

    // R6: a write together with a read leaves fresh data behind.
    a_r6_overlap_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> rd_fresh);

    // R9: with no trigger at all, freshness is kept.
    a_r9_fresh_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> rd_fresh == $past(rd_fresh));
endmodule

bind sample_link sample_link_chk #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_seq(rd_seq), .rd_fresh(rd_fresh)
);

// File: tb/sample_link_bench.sv
// Bench: scoreboard-driven test of the sampling link.
module sample_link_bench;
    localparam int DW = 32;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [SW-1:0] rd_seq;
    logic          rd_fresh;
    logic          sb_sample = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [DW-1:0] d;
        logic [SW-1:0] s;
        logic          f;
        string         tag;
    } exp_t;
    exp_t sbq[$];

    logic [DW-1:0] m_data = '0;
    logic [SW-1:0] m_seq = '0;
    logic [SW-1:0] m_last = '0;

    sample_link #(.DATA_W(DW), .SEQ_W(SW)) u_sample_link (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_seq(rd_seq), .rd_fresh(rd_fresh)
    );

    always #4 clk = ~clk;

    // Driver: apply one cycle of stimulus and optionally queue the expectation.
    task automatic op(input bit w, input logic [DW-1:0] d, input bit r,
                      input bit chk, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; sb_sample = chk;
        if (chk) begin
            e.d = m_data; e.s = m_seq; e.f = (m_seq != m_last); e.tag = tag;
            sbq.push_back(e);
        end
        if (r) m_last = m_seq;
        if (w) begin m_data = d; m_seq = m_seq + 1'b1; end
    endtask

    // Monitor: compare outputs against the queued expectation mid-cycle.
    always @(negedge clk) begin
        #2;
        if (sb_sample && rst_n) begin
            exp_t e;
            if (sbq.size() == 0) begin
                checks++; failures++;
                $display("FAIL %s scoreboard empty", "R4");
            end else begin
                e = sbq.pop_front();
                checks++;
                if (rd_data !== e.d || rd_seq !== e.s || rd_fresh !== e.f) begin
                    failures++;
                    $display("FAIL %s data=%h/%h seq=%0d/%0d fresh=%b/%b (act/exp)",
                             e.tag, rd_data, e.d, rd_seq, e.s, rd_fresh, e.f);
                end
            end
        end
    end

    // Reset-state check, sampled directly.
    task automatic check_reset(input string tag);
        #2;
        checks++;
        if (rd_data !== '0 || rd_seq !== '0 || rd_fresh !== 1'b0) begin
            failures++;
            $display("FAIL %s data=%h seq=%0d fresh=%b expected all zero",
                     tag, rd_data, rd_seq, rd_fresh);
        end
    endtask

    // Watchdog: count a hang as a failure and still report.
    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R1: reset state, during and just after reset.
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; rd_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        check_reset("R1");
        @(negedge clk); rst_n = 1'b1;
        check_reset("R1");

        // R2 / R4: a write, then a read sees it fresh.
        op(1, 32'h1111_AAAA, 0, 0, "");
        op(0, '0, 1, 1, "R2_R4");
        // R5 / R8: repeated reads return stale data, not fresh.
        op(0, '0, 1, 1, "R5_R8");
        op(0, '0, 1, 1, "R8");
        // R6: write and read together: old contents, then fresh.
        op(1, 32'h2222_BBBB, 1, 1, "R6");
        op(0, '0, 0, 1, "R6");
        // R9 / R3: idle keeps fresh and contents.
        op(0, '0, 0, 1, "R9_R3");
        op(0, '0, 1, 1, "R9");
        op(0, '0, 0, 1, "R5");

        // R7: 256 unread writes alias the tag.
        for (int i = 0; i < 256; i++) op(1, 32'h3000_0000 + i, 0, 0, "");
        op(0, '0, 0, 1, "R7");
        op(1, 32'h4444_CCCC, 0, 0, "");
        op(0, '0, 0, 1, "R7");

        // R4: mixed triggers from a shift-register pattern.
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op(lfsr[0], {lfsr, ~lfsr}, lfsr[3], 1, "R4");
        end
        op(0, '0, 0, 1, "R4");

        @(negedge clk); sb_sample = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        #4;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule